// File: doc/BRIEF.md
# Stage-Gain Calibration Coefficient Extractor

This block supports a foreground calibration pass for one stage of a pipelined converter that resolves 1.5 bits per stage. While an external ramp rises and then falls across that stage's upper decision threshold, the block watches the raw output word of the converter and the high bit of the stage's two-bit code. The high bit is 1 only when the stage resolves +1. The codes used are +1 = 2'b10, 0 = 2'b01 and -1 = 2'b00.

A registered copy of the previous word and of the stage bit is kept. Each transition of the stage bit is acted on in the single cycle where it shows up, using the difference "previous word minus current word". On the rising pass, a 0-to-1 transition decides whether the stage capacitors must be exchanged. A difference that needs no borrow means the output fell across the threshold, so the gain is above 2. On the falling pass, a 1-to-0 transition captures the difference as the calibration coefficient and ends the pass. Each result can be written once per pass. A start strobe clears the results and re-arms both captures.

Top module: `stage_cal_extractor`

## Requirements
- R1: After reset, swap_o, coef_o and done_o are all 0.
- R2: With up_ramp_i = 1, a 0-to-1 transition of stage_msb_i whose difference (previous raw code minus current raw code) does not borrow sets swap_o to 1 on the clock edge that samples the transition.
- R3: With up_ramp_i = 1, a 0-to-1 transition whose difference borrows (previous code smaller than current) writes swap_o to 0 and uses up the swap capture.
- R4: With up_ramp_i = 0, a 1-to-0 transition of stage_msb_i loads coef_o with (previous code minus current code) modulo 2^CODE_W on the clock edge that samples the transition.
- R5: After the swap capture has happened, further rising transitions leave swap_o unchanged until the next start.
- R6: After the coefficient capture has happened, further falling transitions leave coef_o unchanged until the next start.
- R7: done_o goes to 1 on the same edge that loads coef_o and stays at 1 until the next start.
- R8: A cycle with start_i = 1 clears swap_o, coef_o and done_o, re-arms both captures and performs no capture itself.
- R9: A rising transition while up_ramp_i = 0 does not touch swap_o, and a falling transition while up_ramp_i = 1 does not touch coef_o or done_o. A capture that is skipped this way stays armed.
- R10: Only a change of stage_msb_i between two consecutive samples counts as a transition. A bit held steady does nothing, and the first sample after reset is never treated as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the results and re-arms both captures |
| up_ramp_i | input | 1 | 1 while the ramp rises, 0 while it falls |
| stage_msb_i | input | 1 | High bit of the calibrated stage's code (1 only for +1) |
| raw_code_i | input | CODE_W | Raw converter output word |
| swap_o | output | 1 | Capacitor exchange request, 1 when the stage gain is above 2 |
| coef_o | output | CODE_W | Captured jump height |
| done_o | output | 1 | Coefficient captured, calibration pass complete |

## Verification
The bench drives both signs of the swap difference. A design that inverted the borrow test, or that never latched a borrow result, would give the wrong swap level, or would let a later no-borrow edge overwrite a 0. It repeats edges after each capture and on the wrong ramp direction, which catches once-only flags that never clear or that are consumed by the wrong direction. It also drives a falling edge whose difference wraps, a stage bit that is already high on the first sample after reset, and a start pulse after a full pass. These expose a coefficient that is truncated wrongly, a false edge taken against reset history, and results or done that survive the re-arm.

// File: rtl/stage_cal_pkg.sv
package stage_cal_pkg;

  // Transition flags of the monitored stage bit for one sample.
  typedef struct packed {
    logic rise;
    logic fall;
  } msb_edge_t;

endpackage

// File: rtl/cal_history.sv
module cal_history #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              msb_i,
  output logic [CODE_W-1:0] code_d_o,
  output logic              msb_d_o,
  output logic              vld_o
);

  logic [CODE_W-1:0] code_q, code_n;
  logic              msb_q, msb_n;
  logic              vld_q, vld_n;

  always_comb begin
    code_n = code_i;
    msb_n  = msb_i;
    vld_n  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      msb_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      msb_q  <= msb_n;
      vld_q  <= vld_n;
    end
  end

  assign code_d_o = code_q;
  assign msb_d_o  = msb_q;
  assign vld_o    = vld_q;

endmodule

// File: rtl/cal_edge_diff.sv
module cal_edge_diff
  import stage_cal_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              msb_i,
  input  logic              msb_d_i,
  input  logic              vld_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] code_d_i,
  output msb_edge_t         edge_o,
  output logic [CODE_W-1:0] diff_o,
  output logic              borrow_o
);

  localparam int EXT_W = CODE_W + 1;

  logic [EXT_W-1:0] wide_diff;

  always_comb begin
    wide_diff   = {1'b0, code_d_i} - {1'b0, code_i};
    diff_o      = wide_diff[CODE_W-1:0];
    borrow_o    = wide_diff[CODE_W];
    edge_o.rise = vld_i & msb_i & ~msb_d_i;
    edge_o.fall = vld_i & ~msb_i & msb_d_i;
  end

endmodule

// File: rtl/cal_capture.sv
module cal_capture
  import stage_cal_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              up_ramp_i,
  input  msb_edge_t         edge_i,
  input  logic [CODE_W-1:0] diff_i,
  input  logic              borrow_i,
  output logic              swap_o,
  output logic [CODE_W-1:0] coef_o,
  output logic              done_o
);

  logic              swap_arm_q, swap_arm_n;
  logic              coef_arm_q, coef_arm_n;
  logic              swap_q, swap_n;
  logic [CODE_W-1:0] coef_q, coef_n;
  logic              done_q, done_n;
  logic              swap_en, coef_en;

  always_comb begin
    swap_en    = !start_i && swap_arm_q && up_ramp_i && edge_i.rise;
    coef_en    = !start_i && coef_arm_q && !up_ramp_i && edge_i.fall;
    swap_arm_n = swap_arm_q;
    coef_arm_n = coef_arm_q;
    swap_n     = swap_q;
    coef_n     = coef_q;
    done_n     = done_q;
    if (start_i) begin
      swap_arm_n = 1'b1;
      coef_arm_n = 1'b1;
      swap_n     = 1'b0;
      coef_n     = '0;
      done_n     = 1'b0;
    end else begin
      if (swap_en) begin
        swap_n     = ~borrow_i;
        swap_arm_n = 1'b0;
      end
      if (coef_en) begin
        coef_n     = diff_i;
        coef_arm_n = 1'b0;
        done_n     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_arm_q <= 1'b1;
      coef_arm_q <= 1'b1;
      swap_q     <= 1'b0;
      coef_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      swap_arm_q <= swap_arm_n;
      coef_arm_q <= coef_arm_n;
      swap_q     <= swap_n;
      coef_q     <= coef_n;
      done_q     <= done_n;
    end
  end

  assign swap_o = swap_q;
  assign coef_o = coef_q;
  assign done_o = done_q;

  // R2 / R3: an armed rising capture writes the inverted borrow
  a_r2_swap_sense: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i.rise && up_ramp_i && swap_arm_q && !start_i) |=> (swap_o == !$past(borrow_i)));

  // R5: once consumed, swap holds until start
  a_r5_swap_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_arm_q && !start_i) |=> $stable(swap_o));

  // R6: once consumed, coefficient holds until start
  a_r6_coef_once: assert property (@(posedge clk) disable iff (!rst_n)
    (!coef_arm_q && !start_i) |=> $stable(coef_o));

  // R7: done is sticky until start
  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R8: start clears every result
  a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!swap_o && !done_o && coef_o == '0));

endmodule

// File: rtl/stage_cal_extractor.sv
module stage_cal_extractor
  import stage_cal_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              up_ramp_i,
  input  logic              stage_msb_i,
  input  logic [CODE_W-1:0] raw_code_i,
  output logic              swap_o,
  output logic [CODE_W-1:0] coef_o,
  output logic              done_o
);

  logic [CODE_W-1:0] code_d;
  logic              msb_d;
  logic              hist_vld;
  msb_edge_t         msb_edge;
  logic [CODE_W-1:0] diff;
  logic              borrow;

  cal_history #(.CODE_W(CODE_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_i   (raw_code_i),
    .msb_i    (stage_msb_i),
    .code_d_o (code_d),
    .msb_d_o  (msb_d),
    .vld_o    (hist_vld)
  );

  cal_edge_diff #(.CODE_W(CODE_W)) u_edge (
    .msb_i    (stage_msb_i),
    .msb_d_i  (msb_d),
    .vld_i    (hist_vld),
    .code_i   (raw_code_i),
    .code_d_i (code_d),
    .edge_o   (msb_edge),
    .diff_o   (diff),
    .borrow_o (borrow)
  );

  cal_capture #(.CODE_W(CODE_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .up_ramp_i (up_ramp_i),
    .edge_i    (msb_edge),
    .diff_i    (diff),
    .borrow_i  (borrow),
    .swap_o    (swap_o),
    .coef_o    (coef_o),
    .done_o    (done_o)
  );

  // R9: a rising ramp never changes the coefficient
  a_r9_coef_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ramp_i && !start_i) |=> $stable(coef_o));

  // R9: a falling ramp never changes swap
  a_r9_swap_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_ramp_i && !start_i) |=> $stable(swap_o));

  // R10: a steady stage bit never triggers a capture
  a_r10_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_msb_i == msb_d && !start_i) |=> ($stable(swap_o) && $stable(coef_o)));

endmodule

// File: tb/tb_stage_cal_extractor.sv
module tb_stage_cal_extractor;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic         up_ramp_i;
  logic         stage_msb_i;
  logic [W-1:0] raw_code_i;
  logic         swap_o;
  logic [W-1:0] coef_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stage_cal_extractor #(.CODE_W(W)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .up_ramp_i   (up_ramp_i),
    .stage_msb_i (stage_msb_i),
    .raw_code_i  (raw_code_i),
    .swap_o      (swap_o),
    .coef_o      (coef_o),
    .done_o      (done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one sample, let it be clocked, return just after the edge.
  task automatic tick(input int code, input bit msb, input bit up, input bit st);
    @(negedge clk);
    raw_code_i  = code[W-1:0];
    stage_msb_i = msb;
    up_ramp_i   = up;
    start_i     = st;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input bit msb);
    @(negedge clk);
    rst_n       = 1'b0;
    start_i     = 1'b0;
    up_ramp_i   = 1'b1;
    stage_msb_i = msb;
    raw_code_i  = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    #1;
    chk("R1 swap", swap_o, 0);
    chk("R1 coef", coef_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_full_pass;
    tick(0, 0, 1, 1);
    tick(100, 0, 1, 0);
    tick(90, 1, 1, 0);
    chk("R2 swap set", swap_o, 1);
    tick(50, 0, 1, 0);
    tick(200, 1, 1, 0);
    chk("R5 swap held", swap_o, 1);
    tick(300, 1, 0, 0);
    chk("R7 done low before capture", done_o, 0);
    tick(280, 0, 0, 0);
    chk("R4 coef", coef_o, 20);
    chk("R7 done set", done_o, 1);
    tick(250, 1, 0, 0);
    tick(100, 0, 0, 0);
    chk("R6 coef held", coef_o, 20);
    chk("R7 done held", done_o, 1);
    tick(100, 0, 0, 1);
    chk("R8 swap cleared", swap_o, 0);
    chk("R8 coef cleared", coef_o, 0);
    chk("R8 done cleared", done_o, 0);
  endtask

  task automatic t_borrow;
    tick(0, 0, 1, 1);
    tick(90, 0, 1, 0);
    tick(100, 1, 1, 0);
    chk("R3 swap low", swap_o, 0);
    tick(200, 0, 1, 0);
    tick(100, 1, 1, 0);
    chk("R3 borrow capture consumed", swap_o, 0);
  endtask

  task automatic t_direction;
    tick(0, 0, 1, 1);
    tick(100, 0, 0, 0);
    tick(90, 1, 0, 0);
    chk("R9 rise on falling ramp ignored", swap_o, 0);
    tick(300, 1, 1, 0);
    tick(280, 0, 1, 0);
    chk("R9 fall on rising ramp coef", coef_o, 0);
    chk("R9 fall on rising ramp done", done_o, 0);
    tick(100, 1, 1, 0);
    chk("R9 swap still armed", swap_o, 1);
    tick(5, 1, 0, 0);
    tick(10, 0, 0, 0);
    chk("R9 coef still armed, R4 wrap", coef_o, 1019);
    chk("R7 done after wrap capture", done_o, 1);
  endtask

  task automatic t_history;
    do_reset(1'b1);
    tick(0, 1, 1, 0);
    chk("R10 first sample not an edge", swap_o, 0);
    tick(0, 1, 1, 0);
    chk("R10 steady high no edge", swap_o, 0);
    tick(50, 0, 1, 0);
    tick(40, 1, 1, 0);
    chk("R10 real edge captured", swap_o, 1);
    tick(40, 0, 1, 1);
    tick(100, 0, 1, 0);
    tick(90, 1, 1, 1);
    chk("R8 no capture in start cycle", swap_o, 0);
  endtask

  initial begin
    rst_n       = 1'b0;
    start_i     = 1'b0;
    up_ramp_i   = 1'b1;
    stage_msb_i = 1'b0;
    raw_code_i  = '0;
    t_reset();
    t_full_pass();
    t_borrow();
    t_direction();
    t_history();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule